// File: doc/BRIEF.md
# Pipelined In-Order Load Stage

This stage turns a stream of addresses into a stream of loaded values. It accepts an address on a ready/valid input and forwards it as a read request to a memory port in the same cycle. That port keeps many reads open at once and answers each one after a variable delay. The returned words are placed in a small response buffer and leave on a ready/valid value output. The stage runs as long as addresses arrive and has no end condition of its own.

Several reads are kept open at the same time, so a slow read (a miss) does not stop the reads queued behind it from being issued. The memory answers in the order it was asked, so no reordering logic is needed. Before a request is issued, the stage reserves a buffer slot for its answer. The memory response channel therefore has no ready signal, and a stalled consumer never causes a word to be lost.

Top module: `load_stream_engine`

## Requirements
- R1: After reset the value output is not valid. With the memory request channel ready and no load open or buffered, the address input reports ready.
- R2: A memory request is valid only while an address is offered, and it carries that address unchanged. An address is accepted in exactly those cycles in which the memory request handshake completes.
- R3: Values leave the stage in the order their addresses were accepted. Each value is the memory's answer for its own address, for any mix of short and long read latencies.
- R4: The number of reads issued but not yet answered never exceeds MAX_OUTSTANDING. When that many reads are open, the stage accepts no further addresses.
- R5: Accepted addresses whose values have not yet left the stage never exceed BUF_DEPTH. When the output is held off, the stage accepts exactly BUF_DEPTH addresses and then stops.
- R6: A memory response has no back-pressure. Every response is taken in the cycle it is valid, and its value eventually appears at the output. No value is lost or duplicated.
- R7: Reads overlap. With a fixed latency of 10 cycles, MAX_OUTSTANDING of 6 and free-flowing ports, 32 loads complete in no more than 120 cycles. Serial issue would need more than 320.
- R8: While the output is valid and not ready, it stays valid and its data stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Address offered |
| addr_ready | output | 1 | Address accepted this cycle if valid |
| addr_data | input | AW | Load address |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read data returned (in request order) |
| mem_rsp_data | input | DW | Returned word |
| val_valid | output | 1 | Loaded value available |
| val_ready | input | 1 | Consumer takes the value |
| val_data | output | DW | Loaded value |

## Verification
A fixed long latency with free-flowing ports separates overlapped issue from one-at-a-time issue, because the total time is either near the load count or near the load count times the latency. Random per-request latency from 1 to 20 cycles, combined with random gaps and random back-pressure on both ports, shows whether order and data survive when short and long reads are interleaved. Holding the output off with a short latency exposes the buffer reservation limit. A very long latency with a draining output exposes the in-flight cap on its own.

// File: rtl/lse_pkg.sv
package lse_pkg;

  // Width of a counter that must hold the values 0..n inclusive.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Width of an index into n slots.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lse_flight_count.sv
module lse_flight_count
  import lse_pkg::*;
#(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW = cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_en  = inc ^ dec;
    cnt_nxt = cnt_q;
    if (inc && !dec)      cnt_nxt = cnt_q + CW'(1);
    else if (dec && !inc) cnt_nxt = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  // R4
  flight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

  // R6
  flight_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |-> (cnt_q != '0));

endmodule

// File: rtl/lse_resp_fifo.sv
module lse_resp_fifo
  import lse_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = idx_width(DEPTH),
  localparam int unsigned FW = cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full,
  output logic [FW-1:0] level
);

  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_nxt, rp_q, rp_nxt;
  logic [FW-1:0] lvl_q, lvl_nxt;
  logic          do_wr, do_rd;

  assign do_wr = wr;
  assign do_rd = rd && (lvl_q != '0);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wp_nxt  = do_wr ? bump(wp_q) : wp_q;
    rp_nxt  = do_rd ? bump(rp_q) : rp_q;
    lvl_nxt = lvl_q;
    if (do_wr && !do_rd)      lvl_nxt = lvl_q + FW'(1);
    else if (do_rd && !do_wr) lvl_nxt = lvl_q - FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_wr)          wp_q  <= wp_nxt;
      if (do_rd)          rp_q  <= rp_nxt;
      if (do_wr ^ do_rd)  lvl_q <= lvl_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && (wp_q == PW'(g))) slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[rp_q];
  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == FW'(DEPTH));
  assign level = lvl_q;

  // R6
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !full);

endmodule

// File: rtl/lse_issue_gate.sv
module lse_issue_gate
  import lse_pkg::*;
#(
  parameter int unsigned MAX_OUT = 8,
  parameter int unsigned DEPTH   = 8,
  localparam int unsigned IW = cnt_width(MAX_OUT),
  localparam int unsigned FW = cnt_width(DEPTH),
  localparam int unsigned SW = ((IW > FW) ? IW : FW) + 1
) (
  input  logic [IW-1:0] open_cnt,
  input  logic [FW-1:0] held_cnt,
  output logic          may_issue
);

  logic [SW-1:0] reserved;
  logic          below_cap, slot_free;

  always_comb begin
    reserved  = SW'(open_cnt) + SW'(held_cnt);
    below_cap = open_cnt < IW'(MAX_OUT);
    slot_free = reserved < SW'(DEPTH);
    may_issue = below_cap && slot_free;
  end

endmodule

// File: rtl/load_stream_engine.sv
module load_stream_engine
  import lse_pkg::*;
#(
  parameter int unsigned AW              = 16,
  parameter int unsigned DW              = 32,
  parameter int unsigned MAX_OUTSTANDING = 8,
  parameter int unsigned BUF_DEPTH       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_valid,
  output logic          addr_ready,
  input  logic [AW-1:0] addr_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          val_valid,
  input  logic          val_ready,
  output logic [DW-1:0] val_data
);

  localparam int unsigned IW = cnt_width(MAX_OUTSTANDING);
  localparam int unsigned FW = cnt_width(BUF_DEPTH);
  localparam int unsigned SW = ((IW > FW) ? IW : FW) + 1;

  logic [IW-1:0] open_cnt;
  logic [FW-1:0] held_cnt;
  logic          may_issue, issue, drain, buf_empty, buf_full;

  lse_issue_gate #(.MAX_OUT(MAX_OUTSTANDING), .DEPTH(BUF_DEPTH)) u_gate (
    .open_cnt (open_cnt),
    .held_cnt (held_cnt),
    .may_issue(may_issue)
  );

  assign mem_req_valid = addr_valid && may_issue;
  assign mem_req_addr  = addr_data;
  assign addr_ready    = mem_req_ready && may_issue;
  assign issue         = mem_req_valid && mem_req_ready;

  lse_flight_count #(.LIMIT(MAX_OUTSTANDING)) u_flight (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (issue),
    .dec  (mem_rsp_valid),
    .cnt  (open_cnt)
  );

  lse_resp_fifo #(.DW(DW), .DEPTH(BUF_DEPTH)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (mem_rsp_valid),
    .wdata(mem_rsp_data),
    .rd   (drain),
    .rdata(val_data),
    .empty(buf_empty),
    .full (buf_full),
    .level(held_cnt)
  );

  assign val_valid = !buf_empty;
  assign drain     = val_valid && val_ready;

  // R5
  reserve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SW'(open_cnt) + SW'(held_cnt)) <= SW'(BUF_DEPTH));

  // R5
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !addr_ready);

  // R8
  val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_valid && !val_ready) |=> (val_valid && $stable(val_data)));

endmodule

// File: tb/sim_load_stream_engine.sv
`timescale 1ns/1ps
module sim_load_stream_engine;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MO = 6;
  localparam int DP = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic addr_valid, addr_ready, mem_req_valid, mem_req_ready;
  logic mem_rsp_valid, val_valid, val_ready;
  logic [AW-1:0] addr_data, mem_req_addr;
  logic [DW-1:0] mem_rsp_data, val_data;

  always #2.5 clk = ~clk;

  load_stream_engine #(.AW(AW), .DW(DW), .MAX_OUTSTANDING(MO), .BUF_DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_data(addr_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .val_valid(val_valid), .val_ready(val_ready), .val_data(val_data)
  );

  typedef struct { logic [DW-1:0] d; int unsigned due; } pend_t;

  int unsigned n_chk = 0, n_fail = 0, cyc = 0;
  int lat_min = 1, lat_max = 1, mreq_pct = 100, vrdy_pct = 100, gap_pct = 0;
  int accepted = 0, popped = 0, open_tb = 0;
  bit drv_busy = 0, stall_prev = 0, done = 0;
  logic [DW-1:0] stall_data;
  logic [DW-1:0] exp_q[$];
  pend_t pend_q[$];

  function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
    return (DW'(a) * 32'd40503) ^ 32'hA5A5_0000;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;

  // memory model and sink ready, driven just after each edge
  always @(posedge clk) begin
    #1;
    mem_req_ready = ($urandom_range(0, 99) < mreq_pct);
    val_ready     = ($urandom_range(0, 99) < vrdy_pct);
    if (rst_n && pend_q.size() > 0 && pend_q[0].due <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pend_q[0].d;
      void'(pend_q.pop_front());
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
    end
  end

  // monitor at mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      bit a_hs, m_hs;
      a_hs = addr_valid && addr_ready;
      m_hs = mem_req_valid && mem_req_ready;
      if (a_hs || mem_req_valid) begin
        check(a_hs == m_hs, "R2", "addr/mem handshake agree", m_hs, a_hs);
        check(addr_valid && mem_req_addr == addr_data, "R2", "request address",
              mem_req_addr, addr_data);
      end
      if (a_hs) begin
        exp_q.push_back(memval(addr_data));
        accepted++;
        check(accepted - popped <= DP, "R5", "accepted minus delivered", accepted - popped, DP);
      end
      if (m_hs) begin
        pend_q.push_back('{memval(mem_req_addr),
                          cyc + unsigned'($urandom_range(lat_min, lat_max))});
        open_tb++;
        check(open_tb <= MO, "R4", "reads open", open_tb, MO);
      end
      if (mem_rsp_valid) open_tb--;
      if (stall_prev) begin
        check(val_valid == 1'b1, "R8", "valid held", val_valid, 1);
        check(val_data == stall_data, "R8", "data held", val_data, stall_data);
      end
      stall_prev = val_valid && !val_ready;
      stall_data = val_data;
      if (val_valid && val_ready) begin
        popped++;
        if (exp_q.size() == 0) check(1'b0, "R6", "unexpected value", val_data, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(val_data == e, "R3", "value in order", val_data, e);
        end
      end
    end
  end

  task automatic send(input int n);
    drv_busy = 1;
    for (int i = 0; i < n; i++) begin
      addr_valid = 1'b0;
      while ($urandom_range(0, 99) < gap_pct) begin
        @(posedge clk); #1;
      end
      addr_valid = 1'b1;
      addr_data  = AW'($urandom);
      do @(negedge clk); while (!addr_ready);
      @(posedge clk); #1;
    end
    addr_valid = 1'b0;
    drv_busy = 0;
  endtask

  task automatic wait_drain();
    while (drv_busy || popped != accepted || open_tb != 0) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R6", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int base, t0;
    rst_n = 1'b0; addr_valid = 1'b0; addr_data = '0;
    mem_req_ready = 1'b1; val_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    check(val_valid == 1'b0, "R1", "valid in reset", val_valid, 0);
    check(mem_req_valid == 1'b0, "R1", "request in reset", mem_req_valid, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(val_valid == 1'b0, "R1", "valid after reset", val_valid, 0);
    check(addr_ready == 1'b1, "R1", "ready after reset", addr_ready, 1);
    @(posedge clk); #1;

    // R7: fixed latency, overlapped issue
    lat_min = 10; lat_max = 10;
    t0 = int'(cyc);
    send(32);
    wait_drain();
    check(int'(cyc) - t0 <= 120, "R7", "cycles for 32 loads", int'(cyc) - t0, 120);

    // R3: random latency, random gaps and back-pressure
    lat_min = 1; lat_max = 20; mreq_pct = 70; vrdy_pct = 60; gap_pct = 30;
    send(300);
    wait_drain();

    // R5: output stalled, buffer reservation limit
    mreq_pct = 100; gap_pct = 0; vrdy_pct = 0; lat_min = 2; lat_max = 2;
    base = accepted;
    fork send(12); join_none
    repeat (40) @(posedge clk);
    #1;
    check(accepted - base == DP, "R5", "accepted while stalled", accepted - base, DP);
    check(val_valid == 1'b1, "R5", "output valid while stalled", val_valid, 1);
    vrdy_pct = 100;
    wait_drain();

    // R4: long latency, in-flight cap
    lat_min = 60; lat_max = 60;
    base = accepted;
    fork send(10); join_none
    repeat (20) @(posedge clk);
    #1;
    check(accepted - base == MO, "R4", "accepted under long latency", accepted - base, MO);
    wait_drain();

    check(exp_q.size() == 0, "R6", "values left undelivered", exp_q.size(), 0);
    check(popped == accepted, "R6", "delivered count", popped, accepted);
    finish_run();
  end

endmodule